// File: doc/BRIEF.md
# Two-Wire Control Register Slave

This block is a fixed-address slave on a two-wire, I2C-compatible serial bus. An external bus master uses it to program a small bank of 8-bit control registers and to read back two live status codes. The bus lines are not used as clocks. The block samples SCL and SDA with its own system clock, through two-flop synchronisers followed by edge detectors. On the SDA side it only drives the output enable of an open-drain pad: when `sda_oe` is high the pad pulls the line low, and otherwise the line floats high.

Each transfer carries exactly one data byte. A write sends the device byte with the direction bit at 0, then a register pointer, then one data byte. A read is done in two parts. The master first writes the pointer. It then issues a repeated START with the direction bit at 1, and the slave returns one byte MSB first, which the master does not acknowledge. Registers 0x00 to 0x0B can be read and written, and their contents appear on a flat output bus. Pointers 0x0E and 0x0F return the rate code and the loss-of-signal code from the status inputs. Bit 0 of register 0x00 shuts the serial port off until the next reset.

Top module: `twi_regfile_slave`

## Requirements
- R1: While reset is asserted and right after it is released, `sda_oe` is low and every writable register reads 0x00 on `cfg_bus`.
- R2: A START is SDA falling while SCL is high, and a STOP is SDA rising while SCL is high. After a START, a device byte whose upper seven bits are 1000100 is acknowledged: `sda_oe` is high throughout the high phase of the ninth SCL pulse.
- R3: A device byte with any other address gets no acknowledge in any slot of that transfer, and no register changes.
- R4: A write transfer (device byte 0x88, pointer, data, STOP) acknowledges both the pointer and the data byte. For a pointer `a` from 0x00 to 0x0B, the data then appears on `cfg_bus[8*a+7:8*a]`.
- R5: A read transfer (device byte 0x88, pointer, repeated START, device byte 0x89) acknowledges the 0x89 byte. The addressed byte is then shifted out MSB first, with `sda_oe` high for each 0 bit. The slave changes `sda_oe` only while SCL is low.
- R6: A read of pointer 0x0E returns `stat_rate` zero-extended to 8 bits. A read of 0x0F returns `stat_los` zero-extended. Both values are taken at the time of the read.
- R7: A write to pointers 0x0C to 0x0F is acknowledged but changes no register. Reads of 0x0C and 0x0D return 0x00.
- R8: A second data byte in the same write transfer is not acknowledged and is not stored.
- R9: Once bit 0 of register 0x00 is written to 1, that bit stays 1. Every later transfer is then ignored (no acknowledge, no write) until reset. The write that sets the bit is still acknowledged.
- R10: A STOP that arrives before the eighth data bit of a write leaves every register unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| scl_in | input | 1 | Serial clock line as seen at the pad |
| sda_in | input | 1 | Serial data line as seen at the pad |
| sda_oe | output | 1 | Open-drain pull-down enable for SDA (1 = drive low) |
| stat_rate | input | 4 | Live rate code returned at pointer 0x0E |
| stat_los | input | 7 | Live loss-of-signal code returned at pointer 0x0F |
| cfg_bus | output | 96 | Writable registers 0x00..0x0B, byte `a` at bits 8*a+7:8*a |

## Verification
Two events can land in the same bus slot. One is the commit of a data byte that sets the interface-disable bit. The other is the link controller's acknowledge of that same byte, which it drives while the new bit is already visible. The bench provokes this by writing 0x01 to register 0x00. It then requires both that the data byte was acknowledged and that the next write and the next read get no acknowledge and leave the registers unchanged. A second reset must bring the port back to life.

// File: rtl/twi_pkg.sv
package twi_pkg;

  localparam int BYTE_W = 8;

  localparam logic [6:0] DEF_DEV_ADDR = 7'b1000100;

  localparam int IFDIS_BIT = 0;

  localparam logic [BYTE_W-1:0] STAT_RATE_PTR = 8'h0E;
  localparam logic [BYTE_W-1:0] STAT_LOS_PTR  = 8'h0F;

  typedef enum logic [3:0] {
    LK_IDLE,
    LK_DEV,
    LK_DEV_ACK,
    LK_REG,
    LK_REG_ACK,
    LK_DAT,
    LK_DAT_ACK,
    LK_TX,
    LK_TX_ACK,
    LK_HOLD
  } link_st_e;

endpackage

// File: rtl/twi_line_sync.sv
module twi_line_sync #(
  parameter int   STAGES   = 2,
  parameter logic IDLE_LVL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic lvl,
  output logic rise,
  output logic fall
);

  logic [STAGES-1:0] pipe_q;
  logic [STAGES-1:0] pipe_d;
  logic              prev_q;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_head
        assign pipe_d[g] = din;
      end else begin : g_tail
        assign pipe_d[g] = pipe_q[g-1];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pipe_q <= {STAGES{IDLE_LVL}};
      prev_q <= IDLE_LVL;
    end else begin
      pipe_q <= pipe_d;
      prev_q <= pipe_q[STAGES-1];
    end
  end

  assign lvl  = pipe_q[STAGES-1];
  assign rise = pipe_q[STAGES-1] & ~prev_q;
  assign fall = ~pipe_q[STAGES-1] & prev_q;

endmodule

// File: rtl/twi_link_fsm.sv
module twi_link_fsm
  import twi_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = DEF_DEV_ADDR
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              sda_lvl,
  input  logic              start_det,
  input  logic              stop_det,
  input  logic              if_disabled,
  input  logic [BYTE_W-1:0] rd_byte,
  output logic              sda_oe,
  output logic              wr_en,
  output logic [BYTE_W-1:0] reg_ptr,
  output logic [BYTE_W-1:0] wr_byte
);

  localparam int               CNT_W    = $clog2(BYTE_W);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(BYTE_W - 1);

  link_st_e          st_q, st_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [BYTE_W-1:0] sh_q, sh_d;
  logic [BYTE_W-1:0] ptr_q, ptr_d;
  logic [BYTE_W-1:0] tx_q, tx_d;
  logic              rd_q, rd_d;
  logic              ph_q, ph_d;
  logic              oe_q, oe_d;
  logic              wr_q, wr_d;
  logic [BYTE_W-1:0] byte_in;

  always_comb begin
    byte_in = {sh_q[BYTE_W-2:0], sda_lvl};
    st_d    = st_q;
    cnt_d   = cnt_q;
    sh_d    = sh_q;
    ptr_d   = ptr_q;
    tx_d    = tx_q;
    rd_d    = rd_q;
    ph_d    = ph_q;
    oe_d    = oe_q;
    wr_d    = 1'b0;
    if (stop_det) begin
      st_d = LK_IDLE;
      oe_d = 1'b0;
      ph_d = 1'b0;
    end else if (start_det) begin
      oe_d  = 1'b0;
      ph_d  = 1'b0;
      cnt_d = '0;
      st_d  = if_disabled ? LK_IDLE : LK_DEV;
    end else begin
      unique case (st_q)
        LK_DEV, LK_REG, LK_DAT: begin
          if (scl_rise) begin
            sh_d  = byte_in;
            cnt_d = cnt_q + 1'b1;
            if (cnt_q == CNT_LAST) begin
              ph_d = 1'b0;
              if (st_q == LK_DEV) begin
                if (byte_in[BYTE_W-1:1] == DEV_ADDR) begin
                  st_d = LK_DEV_ACK;
                  rd_d = byte_in[0];
                end else begin
                  st_d = LK_HOLD;
                end
              end else if (st_q == LK_REG) begin
                ptr_d = byte_in;
                st_d  = LK_REG_ACK;
              end else begin
                wr_d = 1'b1;
                st_d = LK_DAT_ACK;
              end
            end
          end
        end
        LK_DEV_ACK, LK_REG_ACK, LK_DAT_ACK: begin
          if (scl_fall) begin
            if (!ph_q) begin
              ph_d = 1'b1;
              oe_d = 1'b1;
            end else begin
              ph_d = 1'b0;
              oe_d = 1'b0;
              if (st_q == LK_DEV_ACK) begin
                if (rd_q) begin
                  st_d = LK_TX;
                  tx_d = rd_byte;
                  oe_d = ~rd_byte[BYTE_W-1];
                end else begin
                  st_d = LK_REG;
                end
              end else if (st_q == LK_REG_ACK) begin
                st_d = LK_DAT;
              end else begin
                st_d = LK_HOLD;
              end
            end
          end
        end
        LK_TX: begin
          if (scl_rise) begin
            cnt_d = cnt_q + 1'b1;
            if (cnt_q == CNT_LAST) begin
              st_d = LK_TX_ACK;
            end
          end else if (scl_fall) begin
            tx_d = {tx_q[BYTE_W-2:0], 1'b0};
            oe_d = ~tx_q[BYTE_W-2];
          end
        end
        LK_TX_ACK: begin
          if (scl_fall) begin
            oe_d = 1'b0;
          end else if (scl_rise) begin
            st_d = LK_HOLD;
          end
        end
        default: begin
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= LK_IDLE;
      cnt_q <= '0;
      sh_q  <= '0;
      ptr_q <= '0;
      tx_q  <= '0;
      rd_q  <= 1'b0;
      ph_q  <= 1'b0;
      oe_q  <= 1'b0;
      wr_q  <= 1'b0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
      sh_q  <= sh_d;
      ptr_q <= ptr_d;
      tx_q  <= tx_d;
      rd_q  <= rd_d;
      ph_q  <= ph_d;
      oe_q  <= oe_d;
      wr_q  <= wr_d;
    end
  end

  assign sda_oe  = oe_q;
  assign wr_en   = wr_q;
  assign reg_ptr = ptr_q;
  assign wr_byte = sh_q;

endmodule

// File: rtl/twi_reg_bank.sv
module twi_reg_bank
  import twi_pkg::*;
#(
  parameter int NUM_RW = 12,
  parameter int RATE_W = 4,
  parameter int LOS_W  = 7
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic [BYTE_W-1:0]        reg_ptr,
  input  logic [BYTE_W-1:0]        wr_byte,
  input  logic [RATE_W-1:0]        stat_rate,
  input  logic [LOS_W-1:0]         stat_los,
  output logic [BYTE_W-1:0]        rd_byte,
  output logic [NUM_RW*BYTE_W-1:0] cfg_bus
);

  localparam int FLAT_W = NUM_RW * BYTE_W;

  logic [FLAT_W-1:0] cfg_q;
  logic [FLAT_W-1:0] cfg_d;

  genvar g;
  generate
    for (g = 0; g < NUM_RW; g++) begin : g_reg
      logic hit;
      assign hit = wr_en && (reg_ptr == BYTE_W'(g));
      assign cfg_d[g*BYTE_W +: BYTE_W] = hit ? wr_byte : cfg_q[g*BYTE_W +: BYTE_W];
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '0;
    end else if (wr_en) begin
      cfg_q <= cfg_d;
    end
  end

  always_comb begin
    rd_byte = '0;
    if (reg_ptr == STAT_RATE_PTR) begin
      rd_byte = BYTE_W'(stat_rate);
    end else if (reg_ptr == STAT_LOS_PTR) begin
      rd_byte = BYTE_W'(stat_los);
    end else begin
      for (int i = 0; i < NUM_RW; i++) begin
        if (reg_ptr == BYTE_W'(i)) begin
          rd_byte = cfg_q[i*BYTE_W +: BYTE_W];
        end
      end
    end
  end

  assign cfg_bus = cfg_q;

endmodule

// File: rtl/twi_regfile_slave.sv
module twi_regfile_slave
  import twi_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR    = DEF_DEV_ADDR,
  parameter int         NUM_RW      = 12,
  parameter int         SYNC_STAGES = 2,
  parameter int         RATE_W      = 4,
  parameter int         LOS_W       = 7
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     scl_in,
  input  logic                     sda_in,
  output logic                     sda_oe,
  input  logic [RATE_W-1:0]        stat_rate,
  input  logic [LOS_W-1:0]         stat_los,
  output logic [NUM_RW*BYTE_W-1:0] cfg_bus
);

  logic [1:0]        rst_pipe_q;
  logic              rst_int_n;
  logic              scl_lvl, scl_rise, scl_fall;
  logic              sda_lvl, sda_rise, sda_fall;
  logic              start_det, stop_det;
  logic              bank_wr_en;
  logic [BYTE_W-1:0] bank_ptr;
  logic [BYTE_W-1:0] bank_wr_byte;
  logic [BYTE_W-1:0] bank_rd_byte;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe_q <= 2'b00;
    end else begin
      rst_pipe_q <= {rst_pipe_q[0], 1'b1};
    end
  end
  assign rst_int_n = rst_pipe_q[1];

  twi_line_sync #(.STAGES(SYNC_STAGES), .IDLE_LVL(1'b1)) u_scl_sync (
    .clk  (clk),
    .rst_n(rst_int_n),
    .din  (scl_in),
    .lvl  (scl_lvl),
    .rise (scl_rise),
    .fall (scl_fall)
  );

  twi_line_sync #(.STAGES(SYNC_STAGES), .IDLE_LVL(1'b1)) u_sda_sync (
    .clk  (clk),
    .rst_n(rst_int_n),
    .din  (sda_in),
    .lvl  (sda_lvl),
    .rise (sda_rise),
    .fall (sda_fall)
  );

  // SCL steady high across the sampled SDA edge
  assign start_det = sda_fall & scl_lvl & ~scl_rise;
  assign stop_det  = sda_rise & scl_lvl & ~scl_rise;

  twi_link_fsm #(.DEV_ADDR(DEV_ADDR)) u_link (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .scl_rise   (scl_rise),
    .scl_fall   (scl_fall),
    .sda_lvl    (sda_lvl),
    .start_det  (start_det),
    .stop_det   (stop_det),
    .if_disabled(cfg_bus[IFDIS_BIT]),
    .rd_byte    (bank_rd_byte),
    .sda_oe     (sda_oe),
    .wr_en      (bank_wr_en),
    .reg_ptr    (bank_ptr),
    .wr_byte    (bank_wr_byte)
  );

  twi_reg_bank #(.NUM_RW(NUM_RW), .RATE_W(RATE_W), .LOS_W(LOS_W)) u_bank (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .wr_en    (bank_wr_en),
    .reg_ptr  (bank_ptr),
    .wr_byte  (bank_wr_byte),
    .stat_rate(stat_rate),
    .stat_los (stat_los),
    .rd_byte  (bank_rd_byte),
    .cfg_bus  (cfg_bus)
  );

endmodule

// File: rtl/twi_regfile_slave_chk.sv
module twi_regfile_slave_chk #(
  parameter int NUM_RW = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              scl_in,
  input logic              sda_oe,
  input logic [NUM_RW*8-1:0] cfg_bus,
  input logic              wr_en,
  input logic [7:0]        wr_addr,
  input logic [7:0]        wr_data
);

  logic       last_wr;
  logic [7:0] last_addr;
  logic [7:0] last_data;
  logic [7:0] cfg_sel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_wr   <= 1'b0;
      last_addr <= '0;
      last_data <= '0;
    end else begin
      last_wr   <= wr_en;
      last_addr <= wr_addr;
      last_data <= wr_data;
    end
  end

  always_comb begin
    cfg_sel = '0;
    for (int i = 0; i < NUM_RW; i++) begin
      if (last_addr == 8'(i)) begin
        cfg_sel = cfg_bus[i*8 +: 8];
      end
    end
  end

  // R1
  reset_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (sda_oe == 1'b0 && cfg_bus == '0));

  // R3
  only_by_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(cfg_bus));

  // R4
  wr_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (last_wr && last_addr < 8'(NUM_RW)) |-> (cfg_sel == last_data));

  // R5
  drive_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> !scl_in);

  // R7
  ro_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr >= 8'(NUM_RW)) |=> $stable(cfg_bus));

  // R9
  disable_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_bus[0] |=> cfg_bus[0]);

endmodule

bind twi_regfile_slave twi_regfile_slave_chk u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .scl_in (scl_in),
  .sda_oe (sda_oe),
  .cfg_bus(cfg_bus),
  .wr_en  (bank_wr_en),
  .wr_addr(bank_ptr),
  .wr_data(bank_wr_byte)
);

// File: tb/test_twi_regfile_slave.sv
module test_twi_regfile_slave;

  localparam int NUM_RW = 12;
  localparam int QTR    = 10;
  localparam int WD_CYC = 190000;

  typedef struct {
    int          req;
    logic [31:0] val;
  } item_t;

  logic clk = 1'b0;
  logic rst_n;
  logic m_scl, m_sda;
  logic sda_oe;
  logic sda_line;
  logic [3:0] stat_rate;
  logic [6:0] stat_los;
  logic [NUM_RW*8-1:0] cfg_bus;

  item_t       exp_q[$];
  logic [31:0] obs_q[$];
  int n_chk  = 0;
  int n_fail = 0;
  logic [7:0] mdl [NUM_RW];

  always #2 clk = ~clk;

  assign sda_line = m_sda & ~sda_oe;

  twi_regfile_slave i_twi_regfile_slave (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_in   (m_scl),
    .sda_in   (sda_line),
    .sda_oe   (sda_oe),
    .stat_rate(stat_rate),
    .stat_los (stat_los),
    .cfg_bus  (cfg_bus)
  );

  function automatic logic [NUM_RW*8-1:0] mdl_flat();
    logic [NUM_RW*8-1:0] r;
    for (int i = 0; i < NUM_RW; i++) r[i*8 +: 8] = mdl[i];
    return r;
  endfunction

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic score(input int req, input logic [31:0] got, input logic [31:0] want);
    item_t it;
    it.req = req;
    it.val = want;
    exp_q.push_back(it);
    obs_q.push_back(got);
  endtask

  always @(negedge clk) begin
    if (obs_q.size() > 0 && exp_q.size() > 0) begin
      item_t       e;
      logic [31:0] o;
      e = exp_q.pop_front();
      o = obs_q.pop_front();
      n_chk++;
      if (o !== e.val) begin
        n_fail++;
        $display("FAIL R%0d: actual %0h expected %0h", e.req, o, e.val);
      end
    end
  end

  task automatic bus_start();
    m_sda = 1'b1; tick(QTR);
    m_scl = 1'b1; tick(QTR);
    m_sda = 1'b0; tick(QTR);
    m_scl = 1'b0; tick(QTR);
  endtask

  task automatic bus_stop();
    m_sda = 1'b0; tick(QTR);
    m_scl = 1'b1; tick(QTR);
    m_sda = 1'b1; tick(QTR);
  endtask

  task automatic send_bits(input logic [7:0] b, input int n);
    for (int i = 0; i < n; i++) begin
      m_sda = b[7-i]; tick(QTR);
      m_scl = 1'b1;   tick(2*QTR);
      m_scl = 1'b0;   tick(QTR);
    end
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    send_bits(b, 8);
    m_sda = 1'b1; tick(QTR);
    m_scl = 1'b1; tick(QTR);
    ack = sda_oe;
    tick(QTR);
    m_scl = 1'b0; tick(QTR);
  endtask

  task automatic recv_byte(output logic [7:0] b);
    for (int i = 7; i >= 0; i--) begin
      tick(QTR);
      m_scl = 1'b1; tick(QTR);
      b[i] = sda_line;
      tick(QTR);
      m_scl = 1'b0;
    end
    tick(QTR);
    m_sda = 1'b1;
    m_scl = 1'b1; tick(2*QTR);
    m_scl = 1'b0; tick(QTR);
  endtask

  task automatic wr_reg(input logic [7:0] dev, input logic [7:0] ptr, input logic [7:0] dat,
                        output logic a0, output logic a1, output logic a2);
    bus_start();
    send_byte(dev, a0);
    send_byte(ptr, a1);
    send_byte(dat, a2);
    bus_stop();
    tick(QTR);
  endtask

  task automatic rd_reg(input logic [7:0] ptr, output logic a0, output logic a1,
                        output logic a2, output logic [7:0] rb);
    bus_start();
    send_byte(8'h88, a0);
    send_byte(ptr, a1);
    bus_start();
    send_byte(8'h89, a2);
    recv_byte(rb);
    bus_stop();
    tick(QTR);
  endtask

  initial begin : wd
    repeat (WD_CYC) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual still running expected finished");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin : main
    logic a0, a1, a2, a3;
    logic [7:0] rb;
    m_scl = 1'b1;
    m_sda = 1'b1;
    rst_n = 1'b0;
    stat_rate = '0;
    stat_los  = '0;
    for (int i = 0; i < NUM_RW; i++) mdl[i] = 8'h00;
    tick(6);
    rst_n = 1'b1;
    tick(6);

    // R1 reset state
    score(1, 32'(sda_oe), 32'd0);
    score(1, 32'(cfg_bus == '0), 32'd1);

    // R2 / R4 basic write
    wr_reg(8'h88, 8'h03, 8'hA5, a0, a1, a2);
    mdl[3] = 8'hA5;
    score(2, 32'(a0), 32'd1);
    score(4, 32'(a1), 32'd1);
    score(4, 32'(a2), 32'd1);
    score(4, 32'(cfg_bus[3*8 +: 8]), 32'hA5);

    // R4 highest writable register
    wr_reg(8'h88, 8'h0B, 8'h5C, a0, a1, a2);
    mdl[11] = 8'h5C;
    score(4, 32'(cfg_bus[11*8 +: 8]), 32'h5C);

    // R5 read back
    rd_reg(8'h03, a0, a1, a2, rb);
    score(5, 32'(a2), 32'd1);
    score(5, 32'(rb), 32'hA5);
    rd_reg(8'h0B, a0, a1, a2, rb);
    score(5, 32'(rb), 32'h5C);

    // R6 live status
    stat_rate = 4'hA;
    stat_los  = 7'h55;
    rd_reg(8'h0E, a0, a1, a2, rb);
    score(6, 32'(rb), 32'h0A);
    rd_reg(8'h0F, a0, a1, a2, rb);
    score(6, 32'(rb), 32'h55);
    stat_los = 7'h2B;
    rd_reg(8'h0F, a0, a1, a2, rb);
    score(6, 32'(rb), 32'h2B);

    // R7 read-only and unused pointers
    wr_reg(8'h88, 8'h0E, 8'hFF, a0, a1, a2);
    score(7, 32'(a2), 32'd1);
    score(7, 32'(cfg_bus == mdl_flat()), 32'd1);
    wr_reg(8'h88, 8'h0C, 8'h3C, a0, a1, a2);
    score(7, 32'(cfg_bus == mdl_flat()), 32'd1);
    rd_reg(8'h0C, a0, a1, a2, rb);
    score(7, 32'(rb), 32'h00);
    rd_reg(8'h0D, a0, a1, a2, rb);
    score(7, 32'(rb), 32'h00);

    // R3 foreign device address
    wr_reg(8'h8A, 8'h03, 8'h11, a0, a1, a2);
    score(3, 32'(a0), 32'd0);
    score(3, 32'(a1), 32'd0);
    score(3, 32'(a2), 32'd0);
    score(3, 32'(cfg_bus == mdl_flat()), 32'd1);

    // R8 second data byte refused
    bus_start();
    send_byte(8'h88, a0);
    send_byte(8'h04, a1);
    send_byte(8'h3C, a2);
    send_byte(8'h77, a3);
    bus_stop();
    tick(QTR);
    mdl[4] = 8'h3C;
    score(8, 32'(a2), 32'd1);
    score(8, 32'(a3), 32'd0);
    score(8, 32'(cfg_bus[4*8 +: 8]), 32'h3C);

    // R10 STOP inside the data byte
    bus_start();
    send_byte(8'h88, a0);
    send_byte(8'h05, a1);
    send_bits(8'hF0, 4);
    bus_stop();
    tick(QTR);
    score(10, 32'(cfg_bus[5*8 +: 8]), 32'h00);
    score(10, 32'(cfg_bus == mdl_flat()), 32'd1);

    // R4 / R5 control register, interface still enabled
    wr_reg(8'h88, 8'h00, 8'h0E, a0, a1, a2);
    mdl[0] = 8'h0E;
    score(4, 32'(cfg_bus[7:0]), 32'h0E);
    rd_reg(8'h00, a0, a1, a2, rb);
    score(5, 32'(rb), 32'h0E);

    // R9 disable: the setting write is still acknowledged
    wr_reg(8'h88, 8'h00, 8'h01, a0, a1, a2);
    mdl[0] = 8'h01;
    score(9, 32'(a2), 32'd1);
    score(9, 32'(cfg_bus[7:0]), 32'h01);
    wr_reg(8'h88, 8'h03, 8'h99, a0, a1, a2);
    score(9, 32'(a0), 32'd0);
    score(9, 32'(cfg_bus == mdl_flat()), 32'd1);
    rd_reg(8'h03, a0, a1, a2, rb);
    score(9, 32'(a0), 32'd0);
    score(9, 32'(rb), 32'hFF);

    // R1 / R9 reset revives the port
    rst_n = 1'b0;
    tick(4);
    rst_n = 1'b1;
    tick(6);
    for (int i = 0; i < NUM_RW; i++) mdl[i] = 8'h00;
    score(1, 32'(cfg_bus == '0), 32'd1);
    wr_reg(8'h88, 8'h03, 8'h42, a0, a1, a2);
    mdl[3] = 8'h42;
    score(9, 32'(a0), 32'd1);
    score(4, 32'(cfg_bus[3*8 +: 8]), 32'h42);

    tick(8);
    while (exp_q.size() > 0 && obs_q.size() > 0) tick(1);
    n_chk  += exp_q.size();
    n_fail += exp_q.size();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule